// File: doc/BRIEF.md
# Storage Monitor Raster Generator

This block produces the symbol stream for a monitor that always shows a raster of 32 lines by 32 digits. The picture comes from one of three storage elements: the main store, the single-word accumulator, or the control pair made of the current-address word and the present-instruction word. The raster position advances by one digit per clock. The block drives the store's read address with the current raster line and takes the read word back in the same cycle.

For each digit the block emits a one-bit symbol code and a brighten flag. Each source fills the raster in its own way. The store is shown line for line. The accumulator word repeats on every line. The control shows the current-address word on even lines and the present-instruction word on odd lines while the machine runs. While the machine is stopped it shows the current-address word on every line. When the store is on display, the line that matches the action-line address is flagged for brightening.

Top module: `monitor_raster`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sym` and `out_bright` are 0. After release, the first emitted position is line 0, digit 0.
- R2: Emitted positions advance by one digit per clock, from digit 0 to digit 31. After digit 31 comes digit 0 of the next line. After line 31 the raster wraps to line 0, with no gaps.
- R3: With the store in effect, raster line n shows store word n. `store_raddr` carries the raster line that is being scanned.
- R4: With the accumulator selected, every raster line shows `acc_word`.
- R5: With the control selected and `running` high, even lines show `ci_word` and odd lines show `pi_word`.
- R6: With the control selected and `running` low, every line shows `ci_word`.
- R7: `out_sym` is 1 (dash) for a one digit and 0 (dot) for a zero digit. Digit d of a line is bit d of the displayed word.
- R8: `out_bright` is 1 only when the store is in effect and the emitted line equals `action_line`. Every digit of that line is flagged.
- R9: When none of `sel_store`, `sel_acc` and `sel_ctrl` is high, or more than one is high, the store is used.
- R10: Each output reflects the selects, `running`, `action_line` and the word inputs as they stood at the clock edge that captured its position. There is one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_store | input | 1 | Select the store as the source |
| sel_acc | input | 1 | Select the accumulator as the source |
| sel_ctrl | input | 1 | Select the control pair as the source |
| running | input | 1 | Machine is executing instructions |
| action_line | input | 5 | Store line to brighten |
| store_raddr | output | 5 | Store read address (current raster line) |
| store_rdata | input | 32 | Store word at `store_raddr`, combinational |
| acc_word | input | 32 | Accumulator word |
| ci_word | input | 32 | Current-address word |
| pi_word | input | 32 | Present-instruction word |
| out_valid | output | 1 | An emitted position is present |
| out_line | output | 5 | Line of the emitted position |
| out_digit | output | 5 | Digit of the emitted position |
| out_sym | output | 1 | Symbol code: 0 dot, 1 dash |
| out_bright | output | 1 | Brighten flag for this digit |

## Verification
The assertions assume that `store_rdata` settles within the same cycle as `store_raddr`. They also assume that the selects, `running`, `action_line` and the word inputs are stable through each capturing edge. The bench models the store as a combinational array indexed by `store_raddr`. It changes the other inputs only on falling edges, and only after it has checked the output for that cycle. Whole frames are swept under every source, with `running` both high and low, and under invalid select patterns. Each emitted digit is compared against a model built from bit arithmetic.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [1:0] {
    SRC_STORE = 2'd0,
    SRC_ACC   = 2'd1,
    SRC_CTRL  = 2'd2
  } src_t;

  typedef enum logic {
    GLYPH_DOT  = 1'b0,
    GLYPH_DASH = 1'b1
  } glyph_t;

  // Exactly one select raised picks that source; anything else falls back to the store.
  function automatic src_t resolve_src(input logic s_store, input logic s_acc,
                                       input logic s_ctrl);
    logic [2:0] v;
    v = {s_ctrl, s_acc, s_store};
    case (v)
      3'b010:  return SRC_ACC;
      3'b100:  return SRC_CTRL;
      default: return SRC_STORE;
    endcase
  endfunction

  // Control source: the instruction word takes odd lines, only while running.
  function automatic logic ctrl_uses_pi(input logic run, input logic line_odd);
    return run & line_odd;
  endfunction

  function automatic glyph_t glyph_of(input logic digit_bit);
    return digit_bit ? GLYPH_DASH : GLYPH_DOT;
  endfunction

endpackage

// File: rtl/mon_scan_counter.sv
module mon_scan_counter #(
  parameter int LINES  = 32,
  parameter int DIGITS = 32,
  localparam int LW = $clog2(LINES),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [LW-1:0] line_q,
  output logic [DW-1:0] dig_q,
  output logic          last_digit,
  output logic          last_line
);

  localparam logic [DW-1:0] DIG_MAX  = DW'(DIGITS - 1);
  localparam logic [LW-1:0] LINE_MAX = LW'(LINES - 1);

  assign last_digit = (dig_q == DIG_MAX);
  assign last_line  = (line_q == LINE_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q  <= '0;
      line_q <= '0;
    end else if (last_digit) begin
      dig_q  <= '0;
      line_q <= last_line ? '0 : line_q + 1'b1;
    end else begin
      dig_q <= dig_q + 1'b1;
    end
  end

endmodule

// File: rtl/mon_word_select.sv
module mon_word_select
  import mon_pkg::*;
#(
  parameter int W = 32
) (
  input  src_t         src,
  input  logic         running,
  input  logic         line_odd,
  input  logic [W-1:0] store_word,
  input  logic [W-1:0] acc_word,
  input  logic [W-1:0] ci_word,
  input  logic [W-1:0] pi_word,
  output logic [W-1:0] shown_word,
  output logic         using_pi
);

  assign using_pi = (src == SRC_CTRL) && ctrl_uses_pi(running, line_odd);

  always_comb begin
    case (src)
      SRC_ACC:  shown_word = acc_word;
      SRC_CTRL: shown_word = using_pi ? pi_word : ci_word;
      default:  shown_word = store_word;
    endcase
  end

endmodule

// File: rtl/mon_glyph_stage.sv
module mon_glyph_stage
  import mon_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = 5,
  localparam int DW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word,
  input  logic [LW-1:0] line_in,
  input  logic [DW-1:0] dig_in,
  input  logic          bright_in,
  output logic          out_valid,
  output logic [LW-1:0] out_line,
  output logic [DW-1:0] out_digit,
  output logic          out_sym,
  output logic          out_bright
);

  glyph_t glyph_now;
  assign glyph_now = glyph_of(word[dig_in]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_line   <= '0;
      out_digit  <= '0;
      out_sym    <= 1'b0;
      out_bright <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      out_line   <= line_in;
      out_digit  <= dig_in;
      out_sym    <= logic'(glyph_now);
      out_bright <= bright_in;
    end
  end

endmodule

// File: rtl/monitor_raster.sv
module monitor_raster
  import mon_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int DIGITS = 32,
  localparam int LW = $clog2(LINES),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_store,
  input  logic              sel_acc,
  input  logic              sel_ctrl,
  input  logic              running,
  input  logic [LW-1:0]     action_line,
  output logic [LW-1:0]     store_raddr,
  input  logic [DIGITS-1:0] store_rdata,
  input  logic [DIGITS-1:0] acc_word,
  input  logic [DIGITS-1:0] ci_word,
  input  logic [DIGITS-1:0] pi_word,
  output logic              out_valid,
  output logic [LW-1:0]     out_line,
  output logic [DW-1:0]     out_digit,
  output logic              out_sym,
  output logic              out_bright
);

  logic [LW-1:0]     line_q;
  logic [DW-1:0]     dig_q;
  logic              last_digit;
  logic              last_line;
  src_t              eff_src;
  logic [DIGITS-1:0] shown_word;
  logic              using_pi;
  logic              hit_action;

  mon_scan_counter #(.LINES(LINES), .DIGITS(DIGITS)) u_scan (
    .clk(clk), .rst_n(rst_n), .line_q(line_q), .dig_q(dig_q),
    .last_digit(last_digit), .last_line(last_line)
  );

  assign eff_src     = resolve_src(sel_store, sel_acc, sel_ctrl);
  assign store_raddr = line_q;
  assign hit_action  = (eff_src == SRC_STORE) && (line_q == action_line);

  mon_word_select #(.W(DIGITS)) u_sel (
    .src(eff_src), .running(running), .line_odd(line_q[0]),
    .store_word(store_rdata), .acc_word(acc_word), .ci_word(ci_word),
    .pi_word(pi_word), .shown_word(shown_word), .using_pi(using_pi)
  );

  mon_glyph_stage #(.W(DIGITS), .LW(LW)) u_out (
    .clk(clk), .rst_n(rst_n), .word(shown_word), .line_in(line_q),
    .dig_in(dig_q), .bright_in(hit_action), .out_valid(out_valid),
    .out_line(out_line), .out_digit(out_digit), .out_sym(out_sym),
    .out_bright(out_bright)
  );

endmodule

// File: rtl/monitor_raster_chk.sv
module monitor_raster_chk
  import mon_pkg::*;
#(
  parameter int LW = 5,
  parameter int DW = 5,
  parameter int W  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic [LW-1:0] action_line,
  input logic [W-1:0]  acc_word,
  input logic [W-1:0]  ci_word,
  input logic [W-1:0]  pi_word,
  input src_t          eff_src,
  input logic [DW-1:0] dig_q,
  input logic          out_valid,
  input logic [LW-1:0] out_line,
  input logic [DW-1:0] out_digit,
  input logic          out_sym,
  input logic          out_bright
);

  localparam logic [DW-1:0] DIG_MAX = DW'(W - 1);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_bright && !out_sym));

  a_r2_digit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_digit != DIG_MAX) |=>
      (out_digit == $past(out_digit) + 1'b1 && out_line == $past(out_line)));

  a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_digit == DIG_MAX) |=>
      (out_digit == '0 && out_line == $past(out_line) + 1'b1));

  a_r4_acc_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eff_src == SRC_ACC)) |->
      (out_sym == $past(acc_word[dig_q])));

  a_r5_ctrl_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eff_src == SRC_CTRL && running)) |->
      (out_sym == (out_line[0] ? $past(pi_word[dig_q]) : $past(ci_word[dig_q]))));

  a_r6_ctrl_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(eff_src == SRC_CTRL && !running)) |->
      (out_sym == $past(ci_word[dig_q])));

  a_r8_bright_store_line: assert property (@(posedge clk) disable iff (!rst_n)
    out_bright |-> (out_line == $past(action_line) && $past(eff_src == SRC_STORE)));

endmodule

bind monitor_raster monitor_raster_chk #(.LW(LW), .DW(DW), .W(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .action_line(action_line),
  .acc_word(acc_word), .ci_word(ci_word), .pi_word(pi_word),
  .eff_src(eff_src), .dig_q(dig_q), .out_valid(out_valid),
  .out_line(out_line), .out_digit(out_digit), .out_sym(out_sym),
  .out_bright(out_bright)
);

// File: tb/monitor_raster_test.sv
`timescale 1ns/1ps
module monitor_raster_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_store = 1'b0, sel_acc = 1'b0, sel_ctrl = 1'b0, running = 1'b0;
  logic [4:0]  action_line = '0;
  logic [4:0]  store_raddr;
  logic [31:0] store_rdata, acc_word = '0, ci_word = '0, pi_word = '0;
  logic        out_valid, out_sym, out_bright;
  logic [4:0]  out_line, out_digit;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pos = 0;  // bench-side raster position of the next emitted digit

  always #2 clk = ~clk;

  function automatic logic [31:0] store_model(input logic [4:0] n);
    return ({27'd0, n} * 32'h9E37_79B9) ^ {n, 3'b101, n, 19'h2C3A1};
  endfunction

  always_comb store_rdata = store_model(store_raddr);

  monitor_raster uut (
    .clk(clk), .rst_n(rst_n), .sel_store(sel_store), .sel_acc(sel_acc),
    .sel_ctrl(sel_ctrl), .running(running), .action_line(action_line),
    .store_raddr(store_raddr), .store_rdata(store_rdata), .acc_word(acc_word),
    .ci_word(ci_word), .pi_word(pi_word), .out_valid(out_valid),
    .out_line(out_line), .out_digit(out_digit), .out_sym(out_sym),
    .out_bright(out_bright)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (pos %0d)", req, act, exp, pos);
    end
  endtask

  // One cycle: sample at the falling edge against the inputs that stood at the capture edge.
  task automatic step_and_check();
    logic [4:0] l, d;
    logic [31:0] w;
    int mode;
    @(negedge clk);
    l = 5'(pos / 32);
    d = 5'(pos % 32);
    // R9: exactly one select picks its source; otherwise store (0)
    if ({sel_ctrl, sel_acc, sel_store} == 3'b010) mode = 1;
    else if ({sel_ctrl, sel_acc, sel_store} == 3'b100) mode = 2;
    else mode = 0;
    if (mode == 1) w = acc_word;                              // R4
    else if (mode == 2) w = (running && l[0]) ? pi_word : ci_word; // R5 R6
    else w = store_model(l);                                  // R3 R9
    check("R1_valid", 32'(out_valid), 32'd1);
    check("R2_line", 32'(out_line), 32'(l));
    check("R2_digit", 32'(out_digit), 32'(d));
    check("R7_symbol", 32'(out_sym), 32'(w[d]));
    check("R8_bright", 32'(out_bright), 32'((mode == 0) && (l == action_line)));
    pos = (pos + 1) % 1024;
  endtask

  task automatic run_frame();
    for (int i = 0; i < 1024; i++) step_and_check();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1_valid_rst", 32'(out_valid), 32'd0);
    check("R1_sym_rst", 32'(out_sym), 32'd0);
    check("R1_bright_rst", 32'(out_bright), 32'd0);
    check("R3_raddr_rst", 32'(store_raddr), 32'd0);

    sel_store = 1'b1; running = 1'b1; action_line = 5'd5;
    rst_n = 1'b1;
    pos = 0;
    run_frame();                          // R3 R8 store view, line 5 bright
    action_line = 5'd31; running = 1'b0;
    run_frame();                          // R8 boundary line 31
    sel_store = 1'b0; sel_acc = 1'b1; acc_word = 32'h8000_0001;
    run_frame();                          // R4 accumulator repeated
    acc_word = 32'h5A3C_F00F;
    run_frame();                          // R4 second pattern, R10 word change
    sel_acc = 1'b0; sel_ctrl = 1'b1; running = 1'b1;
    ci_word = 32'h0000_0013; pi_word = 32'hC001_A5E2;
    run_frame();                          // R5 alternation
    running = 1'b0;
    run_frame();                          // R6 CI everywhere
    // R10: flip running mid-frame, model follows per position
    for (int i = 0; i < 300; i++) step_and_check();
    running = 1'b1;
    for (int i = 0; i < 724; i++) step_and_check();
    sel_ctrl = 1'b0; action_line = 5'd0;
    run_frame();                          // R9 none selected
    sel_store = 1'b1; sel_acc = 1'b1; sel_ctrl = 1'b1;
    run_frame();                          // R9 all selected
    sel_store = 1'b0;
    run_frame();                          // R9 two selected
    sel_acc = 1'b0; sel_store = 1'b1; action_line = 5'd17;
    for (int i = 0; i < 500; i++) step_and_check();
    // R1: reset mid-frame restarts at line 0 digit 0
    rst_n = 1'b0;
    @(negedge clk);
    check("R1_valid_midrst", 32'(out_valid), 32'd0);
    check("R1_bright_midrst", 32'(out_bright), 32'd0);
    rst_n = 1'b1;
    pos = 0;
    run_frame();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule